// File: doc/BRIEF.md
# Constant-Frequency PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period value and an 8-bit on-time value. It does not count reference clocks directly. It advances only on a single-cycle tick strobe that acts as a clock enable, and a separate rate generator supplies that strobe. Each output cycle therefore lasts a whole number of ticks, and changing the tick rate scales the whole waveform.

A cycle spans `period + 1` ticks. The output is high for the first `on` ticks of each cycle. If `on` exceeds `period`, the output stays high all the time. If `on` is zero, the output stays low. The block takes new period and on-time values only when a cycle completes, so it never emits a truncated cycle. A run enable stops the generator, clears its count and forces the output low.

Top module: `pwm_const_freq`

## Requirements
- R1: While `rst_ni` is low, `pwm_o` is 0 and the internal tick count is 0.
- R2: On a clock edge where `start_i` is 0, the count is cleared. After that edge `pwm_o` is 0 and stays 0 until `start_i` is sampled high again.
- R3: While running, one output cycle lasts `period + 1` ticks. `pwm_o` is 1 while the count since the cycle began (0 to `period`) is below `on`, so the high fraction is on/(period+1).
- R4: When the active `on` value is greater than the active `period` value, `pwm_o` stays 1 for the whole run (for example on=0xFF with period=0xFE).
- R5: When the active `on` value is 0, `pwm_o` stays 0 while running.
- R6: New `period_i` and `on_i` values take effect only on the tick that ends the current cycle. Changes made mid-cycle do not alter the cycle in progress.
- R7: Clock edges with `tick_i` low do not advance the count or change `pwm_o` while running.
- R8: The first clock edge with `start_i` high after a stop captures `period_i` and `on_i` and begins a cycle at count 0. `pwm_o` is 1 right after that edge if `on` is nonzero. Ticks on that edge are not counted.
- R9: With period 0, every tick completes a cycle. `pwm_o` is constantly 1 for a nonzero `on` and constantly 0 for `on` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable strobe from the rate generator |
| start_i | input | 1 | Run enable; low stops, clears and silences the output |
| period_i | input | 8 | Cycle length minus one, in ticks |
| on_i | input | 8 | High time in ticks |
| pwm_o | output | 1 | PWM output |

## Verification
A wrong count or a wrong latched setting moves the edges of `pwm_o`. The bench compares `pwm_o` against a tick-level model on every clock, so most faults show up within one output cycle: no more than `period + 1` ticks after the first divergence. A latch-timing fault, where a value is taken mid-cycle instead of at the wrap, shows up within the cycle in which the new value is written. A stuck run state shows up on the first clock after `start_i` changes.

// File: rtl/pwm_cf_pkg.sv
package pwm_cf_pkg;
  parameter int unsigned CNT_W = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/pwm_cf_ctrl.sv
module pwm_cf_ctrl
  import pwm_cf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  input  logic wrap_i,
  output logic run_o,
  output logic load_o,
  output logic clear_o,
  output logic adv_o
);
  run_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!start_i) st_d = ST_IDLE;
    else          st_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  logic running;
  assign running = (st_q == ST_RUN);
  assign run_o   = running;
  // settings are taken while stopped, on the start edge, and at each wrap
  assign load_o  = !start_i || !running || (tick_i && wrap_i);
  assign clear_o = load_o;
  assign adv_o   = start_i && running && tick_i && !wrap_i;

  a_r8_start_begins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !running) |=> run_o);
  a_r2_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !run_o);
endmodule

// File: rtl/pwm_cf_shadow.sv
module pwm_cf_shadow #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] period_i,
  input  logic [WIDTH-1:0] on_i,
  output logic [WIDTH-1:0] period_o,
  output logic [WIDTH-1:0] on_o
);
  logic [WIDTH-1:0] per_q, on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      on_q  <= '0;
    end else if (load_i) begin
      per_q <= period_i;
      on_q  <= on_i;
    end
  end

  assign period_o = per_q;
  assign on_o     = on_q;
endmodule

// File: rtl/pwm_cf_counter.sv
module pwm_cf_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] period_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv_i)   cnt_q <= cnt_q + WIDTH'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == period_i);

  a_r3_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= period_i));
  a_r7_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && start_i && !tick_i) |=> $stable(cnt_q));
  a_r3_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && start_i && tick_i && (cnt_q != period_i)) |=> (cnt_q == $past(cnt_q) + WIDTH'(1)));
endmodule

// File: rtl/pwm_cf_compare.sv
module pwm_cf_compare #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             run_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic [WIDTH-1:0] on_i,
  output logic             pwm_o
);
  assign pwm_o = run_i && (cnt_i < on_i);
endmodule

// File: rtl/pwm_const_freq.sv
module pwm_const_freq
  import pwm_cf_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [WIDTH-1:0] period_i,
  input  logic [WIDTH-1:0] on_i,
  output logic             pwm_o
);
  logic             run, load, clear, adv, wrap;
  logic [WIDTH-1:0] per_q, on_q, cnt;

  pwm_cf_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .tick_i,
    .wrap_i  (wrap),
    .run_o   (run),
    .load_o  (load),
    .clear_o (clear),
    .adv_o   (adv)
  );

  pwm_cf_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk_i, .rst_ni,
    .load_i   (load),
    .period_i (period_i),
    .on_i     (on_i),
    .period_o (per_q),
    .on_o     (on_q)
  );

  pwm_cf_counter #(.WIDTH(WIDTH)) u_counter (
    .clk_i, .rst_ni,
    .clear_i  (clear),
    .adv_i    (adv),
    .run_i    (run),
    .tick_i   (tick_i),
    .start_i  (start_i),
    .period_i (per_q),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  pwm_cf_compare #(.WIDTH(WIDTH)) u_cmp (
    .run_i (run),
    .cnt_i (cnt),
    .on_i  (on_q),
    .pwm_o (pwm_o)
  );

  a_r1_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (!pwm_o && cnt == '0));
  a_r2_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (cnt == '0 && !pwm_o));
  a_r4_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && on_q > per_q) |-> pwm_o);
  a_r5_zero_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_q == '0) |-> !pwm_o);
  a_r6_latch_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start_i && !(tick_i && cnt == per_q)) |=> ($stable(per_q) && $stable(on_q)));
  a_r8_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run) |-> (cnt == '0));
endmodule

// File: tb/pwm_const_freq_test.sv
module pwm_const_freq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic [7:0] per = 8'd0;
  logic [7:0] on_t = 8'd0;
  logic       pwm;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_const_freq uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .start_i  (start),
    .period_i (per),
    .on_i     (on_t),
    .pwm_o    (pwm)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0, tick_div = 1;
  string req = "R1";
  int    m_run = 0, m_cnt = 0, m_per = 0, m_on = 0;
  bit    done = 0;

  // tick-level reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_per = 0; m_on = 0;
    end else if (!start) begin
      m_run = 0; m_cnt = 0; m_per = int'(per); m_on = int'(on_t);
    end else if (m_run == 0) begin
      m_run = 1; m_cnt = 0; m_per = int'(per); m_on = int'(on_t);
    end else if (tick) begin
      if (m_cnt >= m_per) begin
        m_cnt = 0; m_per = int'(per); m_on = int'(on_t);
      end else m_cnt = m_cnt + 1;
    end
  end

  task automatic check(input bit exp);
    n_chk++;
    if (pwm !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: pwm_o=%b expected %b", req, cyc, pwm, exp);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(m_run != 0 && m_cnt < m_on);
      cyc++;
      tick = (tick_div == 0) ? 1'b0 : ((cyc % tick_div) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1"; check(1'b0);
    rst_n = 1'b1;
    req = "R2"; per = 8'd5; on_t = 8'd3; run(10);
    req = "R8"; start = 1'b1; run(3);
    req = "R3"; run(40);
    tick_div = 3; run(60);
    req = "R6"; per = 8'd9; on_t = 8'd7; run(7);
    per = 8'd3; on_t = 8'd1; run(11);
    per = 8'd12; on_t = 8'd6; run(80);
    req = "R7"; tick_div = 0; run(25);
    tick_div = 2; run(30);
    req = "R5"; per = 8'd6; on_t = 8'd0; run(40);
    req = "R4"; tick_div = 1; per = 8'd4; on_t = 8'd9; run(30);
    per = 8'hFE; on_t = 8'hFF; run(600);
    req = "R3"; per = 8'hFF; on_t = 8'h80; run(600);
    req = "R9"; per = 8'd0; on_t = 8'd1; run(270);
    on_t = 8'd0; run(10);
    req = "R2"; start = 1'b0; per = 8'd7; on_t = 8'd2; run(12);
    req = "R8"; start = 1'b1; tick_div = 1; run(30);
    req = "R2"; start = 1'b0; run(1); start = 1'b1; run(20);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule